// File: doc/BRIEF.md
# Outstanding-EOI Tracker for a Coalescing Edge Line

This block keeps account of which destination processors still owe an end-of-interrupt (EOI) for a single edge-triggered interrupt line that must not be re-delivered while an earlier instance is unacknowledged. While any acknowledgment is outstanding the line is flagged as coalesced, and a new delivery offered to the block is refused.

When the surrounding interrupt logic delivers the line, it presents the set of destinations that accepted it, the number of acceptances and the vector used. The block records a pending bit and the vector for every destination reached, and loads its pending count. Each EOI arrives tagged with a destination index and a vector. An EOI retires a pending bit only when the bit is set and the vector matches the recorded one. A per-destination restore input lets software-visible state or a migration path set or clear a single pending bit. If a retirement would take the count below zero, the block rebuilds the bitmap and the count from the live per-destination pending status supplied at its input. A registered query port reports the pending bit and the stored vector of any destination, so that a missed EOI can be recognised.

Top module: `eoi_track`

## Requirements
- R1: A synchronous active-high reset clears the pending count, the pending bitmap, every stored vector and all registered outputs (coalesced, req_drop, resync, qry_pend, qry_vec).
- R2: `coalesced` is 1 exactly when the pending count is nonzero, in the same cycle as the count.
- R3: A delivery (`dlv_valid`) is taken only when the pending count is 0 and neither `restore_valid` nor `eoi_valid` is high. With `dlv_ok`=1 it loads the bitmap with `dlv_map` (bit i = destination i), the count with `dlv_count`, and the vector `dlv_vec` for every destination whose bit is set. With `dlv_ok`=0 the bitmap and count become 0.
- R4: A delivery that is not taken leaves count, bitmap and vectors unchanged, and `req_drop` is 1 in the following cycle only.
- R5: An EOI whose destination bit is set and whose vector equals that destination's stored vector clears the bit and lowers the count by 1 when the count is above 0.
- R6: An EOI for a destination whose bit is clear, or with a vector different from the stored one, changes nothing.
- R7: A restore (`restore_valid`) whose requested value `restore_pend` equals the current bit changes nothing; one that sets a bit stores `line_vec` for it and raises the count by 1, holding at the maximum count value 2^CNT_W-1; one that clears a bit is a retirement handled as in R5 and R8.
- R8: A retirement (R5 or a clearing restore) while the count is 0 loads the bitmap from `dest_live`, the count with the number of ones in `dest_live`, `line_vec` as the vector for every set destination, and pulses `resync` for one cycle.
- R9: Events in one cycle are taken in priority restore, then EOI, then delivery; a lower-priority event in the same cycle has no effect, and a refused delivery raises `req_drop` as in R4.
- R10: `qry_pend` and `qry_vec` show, one cycle after `qry_dest` is presented, the pending bit and stored vector of that destination as they were before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dlv_valid | input | 1 | Delivery of the line is offered |
| dlv_ok | input | 1 | Delivery reached at least the reported destinations (0 = failed) |
| dlv_map | input | NUM_DEST | Destinations that accepted, bit i = destination i |
| dlv_count | input | CNT_W | Number of acceptances reported by the delivery path |
| dlv_vec | input | VEC_W | Vector used for the delivery |
| eoi_valid | input | 1 | EOI event |
| eoi_dest | input | DID_W | Destination index issuing the EOI |
| eoi_vec | input | VEC_W | Vector named by the EOI |
| restore_valid | input | 1 | Per-destination restore event |
| restore_dest | input | DID_W | Destination index to restore |
| restore_pend | input | 1 | Requested pending value for that destination |
| line_vec | input | VEC_W | Vector currently programmed for the line |
| dest_live | input | NUM_DEST | Live per-destination pending status used for a rebuild |
| qry_dest | input | DID_W | Destination index to report |
| coalesced | output | 1 | Line has outstanding acknowledgments |
| pend_count | output | CNT_W | Pending acknowledgment count |
| pend_map | output | NUM_DEST | Pending bitmap |
| req_drop | output | 1 | Previous cycle's delivery was refused |
| resync | output | 1 | Bitmap and count were rebuilt at the last edge |
| qry_pend | output | 1 | Pending bit of the queried destination |
| qry_vec | output | VEC_W | Stored vector of the queried destination |

## Verification
The bench aims at an EOI with the right destination but a stale vector, which a design that ignores the stored vector would wrongly retire, and at a delivery offered while the count is nonzero, which a broken gate would accept and overwrite the bitmap with. It drives a delivery whose reported count is smaller than its bitmap so that a later EOI hits a zero count; a design without the rebuild would wrap the counter to its maximum and stay coalesced forever. It also pushes the count to its top value before a setting restore, where a missing saturation wraps to zero and drops the coalesced flag, and it fires restore, EOI and delivery together to expose a wrong priority.

// File: rtl/eoi_track_pkg.sv
package eoi_track_pkg;

  localparam int unsigned ONES_MAX_W = 256;

  function automatic int unsigned count_ones(input logic [ONES_MAX_W-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < ONES_MAX_W; i++) begin
      n = n + int'(v[i]);
    end
    return n;
  endfunction

  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_RESTORE = 2'd1,
    EV_EOI     = 2'd2,
    EV_DELIVER = 2'd3
  } ev_kind_t;

endpackage

// File: rtl/eoi_track_vecs.sv
module eoi_track_vecs #(
  parameter int NUM_DEST = 8,
  parameter int VEC_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_DEST-1:0]       wr_mask,
  input  logic [VEC_W-1:0]          wr_data,
  output logic [NUM_DEST*VEC_W-1:0] vec_all
);

  for (genvar g = 0; g < NUM_DEST; g++) begin : g_slot
    logic [VEC_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q <= '0;
      end else if (wr_mask[g]) begin
        slot_q <= wr_data;
      end
    end
    assign vec_all[g*VEC_W +: VEC_W] = slot_q;
  end

endmodule

// File: rtl/eoi_track_query.sv
module eoi_track_query #(
  parameter int NUM_DEST = 8,
  parameter int VEC_W    = 8,
  parameter int DID_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [DID_W-1:0]          qry_dest,
  input  logic [NUM_DEST-1:0]       map_q,
  input  logic [NUM_DEST*VEC_W-1:0] vec_all,
  output logic                      qry_pend,
  output logic [VEC_W-1:0]          qry_vec
);

  always_ff @(posedge clk) begin
    if (rst) begin
      qry_pend <= 1'b0;
      qry_vec  <= '0;
    end else begin
      qry_pend <= map_q[qry_dest];
      qry_vec  <= vec_all[qry_dest*VEC_W +: VEC_W];
    end
  end

endmodule

// File: rtl/eoi_track_ctrl.sv
module eoi_track_ctrl
  import eoi_track_pkg::*;
#(
  parameter int NUM_DEST = 8,
  parameter int VEC_W    = 8,
  parameter int CNT_W    = 4,
  parameter int DID_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      dlv_valid,
  input  logic                      dlv_ok,
  input  logic [NUM_DEST-1:0]       dlv_map,
  input  logic [CNT_W-1:0]          dlv_count,
  input  logic [VEC_W-1:0]          dlv_vec,
  input  logic                      eoi_valid,
  input  logic [DID_W-1:0]          eoi_dest,
  input  logic [VEC_W-1:0]          eoi_vec,
  input  logic                      restore_valid,
  input  logic [DID_W-1:0]          restore_dest,
  input  logic                      restore_pend,
  input  logic [VEC_W-1:0]          line_vec,
  input  logic [NUM_DEST-1:0]       dest_live,
  input  logic [NUM_DEST*VEC_W-1:0] vec_all,
  output logic [NUM_DEST-1:0]       wr_mask,
  output logic [VEC_W-1:0]          wr_data,
  output logic [NUM_DEST-1:0]       map_q,
  output logic [CNT_W-1:0]          cnt_q,
  output logic                      coal_q,
  output logic                      drop_q,
  output logic                      sync_q
);

  localparam logic [CNT_W-1:0]    CNT_MAX = '1;
  localparam logic [CNT_W-1:0]    CNT_ONE = CNT_W'(1);
  localparam logic [NUM_DEST-1:0] HOT_0   = NUM_DEST'(1);

  ev_kind_t            kind;
  logic [NUM_DEST-1:0] rs_hot, eoi_hot, clr_hot;
  logic [VEC_W-1:0]    eoi_stored;
  logic                clr;
  logic [NUM_DEST-1:0] map_n;
  logic [CNT_W-1:0]    cnt_n;
  logic                drop_n, sync_n;

  // priority selection of the event served this cycle
  always_comb begin
    if (restore_valid)  kind = EV_RESTORE;
    else if (eoi_valid) kind = EV_EOI;
    else if (dlv_valid) kind = EV_DELIVER;
    else                kind = EV_NONE;
  end

  assign rs_hot     = HOT_0 << restore_dest;
  assign eoi_hot    = HOT_0 << eoi_dest;
  assign eoi_stored = vec_all[eoi_dest*VEC_W +: VEC_W];

  always_comb begin
    map_n   = map_q;
    cnt_n   = cnt_q;
    wr_mask = '0;
    wr_data = line_vec;
    drop_n  = dlv_valid && (kind != EV_DELIVER);
    sync_n  = 1'b0;
    clr     = 1'b0;
    clr_hot = '0;
    unique case (kind)
      EV_RESTORE: begin
        if (map_q[restore_dest] != restore_pend) begin
          if (restore_pend) begin
            map_n   = map_q | rs_hot;
            cnt_n   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
            wr_mask = rs_hot;
          end else begin
            clr     = 1'b1;
            clr_hot = rs_hot;
          end
        end
      end
      EV_EOI: begin
        if (map_q[eoi_dest] && (eoi_stored == eoi_vec)) begin
          clr     = 1'b1;
          clr_hot = eoi_hot;
        end
      end
      EV_DELIVER: begin
        if (cnt_q == '0) begin
          map_n   = dlv_ok ? dlv_map : '0;
          cnt_n   = dlv_ok ? dlv_count : '0;
          wr_mask = dlv_ok ? dlv_map : '0;
          wr_data = dlv_vec;
        end else begin
          drop_n = 1'b1;
        end
      end
      default: ;
    endcase
    if (clr) begin
      if (cnt_q == '0) begin
        // count would underflow: rebuild from the live status
        map_n   = dest_live;
        cnt_n   = CNT_W'(count_ones(ONES_MAX_W'(dest_live)));
        wr_mask = dest_live;
        wr_data = line_vec;
        sync_n  = 1'b1;
      end else begin
        map_n = map_q & ~clr_hot;
        cnt_n = cnt_q - CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q  <= '0;
      cnt_q  <= '0;
      coal_q <= 1'b0;
      drop_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      map_q  <= map_n;
      cnt_q  <= cnt_n;
      coal_q <= (cnt_n != '0);
      drop_q <= drop_n;
      sync_q <= sync_n;
    end
  end

endmodule

// File: rtl/eoi_track.sv
module eoi_track #(
  parameter int NUM_DEST = 8,
  parameter int VEC_W    = 8,
  parameter int CNT_W    = 4,
  parameter int DID_W    = $clog2(NUM_DEST)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dlv_valid,
  input  logic                dlv_ok,
  input  logic [NUM_DEST-1:0] dlv_map,
  input  logic [CNT_W-1:0]    dlv_count,
  input  logic [VEC_W-1:0]    dlv_vec,
  input  logic                eoi_valid,
  input  logic [DID_W-1:0]    eoi_dest,
  input  logic [VEC_W-1:0]    eoi_vec,
  input  logic                restore_valid,
  input  logic [DID_W-1:0]    restore_dest,
  input  logic                restore_pend,
  input  logic [VEC_W-1:0]    line_vec,
  input  logic [NUM_DEST-1:0] dest_live,
  input  logic [DID_W-1:0]    qry_dest,
  output logic                coalesced,
  output logic [CNT_W-1:0]    pend_count,
  output logic [NUM_DEST-1:0] pend_map,
  output logic                req_drop,
  output logic                resync,
  output logic                qry_pend,
  output logic [VEC_W-1:0]    qry_vec
);

  logic [NUM_DEST*VEC_W-1:0] vec_all;
  logic [NUM_DEST-1:0]       wr_mask;
  logic [VEC_W-1:0]          wr_data;

  eoi_track_ctrl #(
    .NUM_DEST(NUM_DEST), .VEC_W(VEC_W), .CNT_W(CNT_W), .DID_W(DID_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .dlv_valid(dlv_valid), .dlv_ok(dlv_ok), .dlv_map(dlv_map),
    .dlv_count(dlv_count), .dlv_vec(dlv_vec),
    .eoi_valid(eoi_valid), .eoi_dest(eoi_dest), .eoi_vec(eoi_vec),
    .restore_valid(restore_valid), .restore_dest(restore_dest),
    .restore_pend(restore_pend), .line_vec(line_vec), .dest_live(dest_live),
    .vec_all(vec_all), .wr_mask(wr_mask), .wr_data(wr_data),
    .map_q(pend_map), .cnt_q(pend_count), .coal_q(coalesced),
    .drop_q(req_drop), .sync_q(resync)
  );

  eoi_track_vecs #(
    .NUM_DEST(NUM_DEST), .VEC_W(VEC_W)
  ) u_vecs (
    .clk(clk), .rst(rst), .wr_mask(wr_mask), .wr_data(wr_data),
    .vec_all(vec_all)
  );

  eoi_track_query #(
    .NUM_DEST(NUM_DEST), .VEC_W(VEC_W), .DID_W(DID_W)
  ) u_query (
    .clk(clk), .rst(rst), .qry_dest(qry_dest), .map_q(pend_map),
    .vec_all(vec_all), .qry_pend(qry_pend), .qry_vec(qry_vec)
  );

endmodule

// File: rtl/eoi_track_chk.sv
module eoi_track_chk #(
  parameter int NUM_DEST = 8,
  parameter int CNT_W    = 4,
  parameter int DID_W    = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                dlv_valid,
  input logic                eoi_valid,
  input logic [DID_W-1:0]    eoi_dest,
  input logic                restore_valid,
  input logic [DID_W-1:0]    restore_dest,
  input logic                restore_pend,
  input logic                coalesced,
  input logic [CNT_W-1:0]    pend_count,
  input logic [NUM_DEST-1:0] pend_map,
  input logic                req_drop,
  input logic                resync
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pend_count == '0) && (pend_map == '0) && !coalesced && !req_drop && !resync);

  // R2
  coal_match_chk: assert property (@(posedge clk) disable iff (rst)
    coalesced == (pend_count != '0));

  // R4
  drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && !restore_valid && !eoi_valid && (pend_count != '0))
      |=> req_drop && $stable(pend_count) && $stable(pend_map));

  // R6
  eoi_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (eoi_valid && !restore_valid && !pend_map[eoi_dest])
      |=> $stable(pend_map) && $stable(pend_count));

  // R7
  restore_set_chk: assert property (@(posedge clk) disable iff (rst)
    (restore_valid && restore_pend) |=> pend_map[$past(restore_dest)]);

  // R8
  resync_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    resync |-> (int'(pend_count) == $countones(pend_map)));

endmodule

bind eoi_track eoi_track_chk #(
  .NUM_DEST(NUM_DEST), .CNT_W(CNT_W), .DID_W(DID_W)
) u_chk (
  .clk(clk), .rst(rst), .dlv_valid(dlv_valid), .eoi_valid(eoi_valid),
  .eoi_dest(eoi_dest), .restore_valid(restore_valid),
  .restore_dest(restore_dest), .restore_pend(restore_pend),
  .coalesced(coalesced), .pend_count(pend_count), .pend_map(pend_map),
  .req_drop(req_drop), .resync(resync)
);

// File: tb/eoi_track_test.sv
module eoi_track_test;

  localparam int ND = 8;
  localparam int VW = 8;
  localparam int CW = 4;
  localparam int DW = 3;
  localparam int CMAX = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic          dlv_valid = 0, dlv_ok = 0, eoi_valid = 0, restore_valid = 0, restore_pend = 0;
  logic [ND-1:0] dlv_map = '0, dest_live = '0;
  logic [CW-1:0] dlv_count = '0;
  logic [VW-1:0] dlv_vec = '0, eoi_vec = '0, line_vec = '0;
  logic [DW-1:0] eoi_dest = '0, restore_dest = '0, qry_dest = '0;

  logic          coalesced, req_drop, resync, qry_pend;
  logic [CW-1:0] pend_count;
  logic [ND-1:0] pend_map;
  logic [VW-1:0] qry_vec;

  eoi_track #(.NUM_DEST(ND), .VEC_W(VW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst),
    .dlv_valid(dlv_valid), .dlv_ok(dlv_ok), .dlv_map(dlv_map),
    .dlv_count(dlv_count), .dlv_vec(dlv_vec),
    .eoi_valid(eoi_valid), .eoi_dest(eoi_dest), .eoi_vec(eoi_vec),
    .restore_valid(restore_valid), .restore_dest(restore_dest),
    .restore_pend(restore_pend), .line_vec(line_vec), .dest_live(dest_live),
    .qry_dest(qry_dest), .coalesced(coalesced), .pend_count(pend_count),
    .pend_map(pend_map), .req_drop(req_drop), .resync(resync),
    .qry_pend(qry_pend), .qry_vec(qry_vec)
  );

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  bit    started = 0;
  string tag = "R1";

  // behavioural reference state
  bit m_map[ND];
  int m_vec[ND];
  int m_cnt;
  bit m_drop, m_sync, m_qp;
  int m_qv;

  task automatic check(input string nm, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, nm, act, exp, $time);
    end
  endtask

  function automatic logic [ND-1:0] model_map();
    logic [ND-1:0] v;
    for (int i = 0; i < ND; i++) v[i] = m_map[i];
    return v;
  endfunction

  task automatic model_retire(input int d);
    if (m_cnt == 0) begin
      m_cnt = 0;
      for (int i = 0; i < ND; i++) begin
        m_map[i] = dest_live[i];
        if (dest_live[i]) begin
          m_vec[i] = line_vec;
          m_cnt++;
        end
      end
      m_sync = 1;
    end else begin
      m_map[d] = 0;
      m_cnt--;
    end
  endtask

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      for (int i = 0; i < ND; i++) begin m_map[i] = 0; m_vec[i] = 0; end
      m_cnt = 0; m_drop = 0; m_sync = 0; m_qp = 0; m_qv = 0;
    end else begin
      m_qp = m_map[qry_dest];
      m_qv = m_vec[qry_dest];
      m_drop = 0;
      m_sync = 0;
      if (restore_valid) begin
        if (m_map[restore_dest] != restore_pend) begin
          if (restore_pend) begin
            m_map[restore_dest] = 1;
            m_vec[restore_dest] = line_vec;
            if (m_cnt < CMAX) m_cnt++;
          end else begin
            model_retire(restore_dest);
          end
        end
        if (dlv_valid) m_drop = 1;
      end else if (eoi_valid) begin
        if (m_map[eoi_dest] && m_vec[eoi_dest] == int'(eoi_vec)) model_retire(eoi_dest);
        if (dlv_valid) m_drop = 1;
      end else if (dlv_valid) begin
        if (m_cnt == 0) begin
          for (int i = 0; i < ND; i++) begin
            m_map[i] = dlv_ok && dlv_map[i];
            if (m_map[i]) m_vec[i] = dlv_vec;
          end
          m_cnt = dlv_ok ? int'(dlv_count) : 0;
        end else begin
          m_drop = 1;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      check("coalesced", 32'(coalesced), 32'(m_cnt != 0));
      check("pend_count", 32'(pend_count), 32'(m_cnt));
      check("pend_map", 32'(pend_map), 32'(model_map()));
      check("req_drop", 32'(req_drop), 32'(m_drop));
      check("resync", 32'(resync), 32'(m_sync));
      check("qry_pend", 32'(qry_pend), 32'(m_qp));
      check("qry_vec", 32'(qry_vec), 32'(m_qv));
    end
  end

  task automatic clear_ev();
    @(negedge clk);
    dlv_valid = 0; eoi_valid = 0; restore_valid = 0;
    qry_dest = DW'($urandom % ND);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) clear_ev();
  endtask

  task automatic deliver(input bit ok, input logic [ND-1:0] mp, input int cnt, input int vec);
    clear_ev();
    dlv_valid = 1; dlv_ok = ok; dlv_map = mp; dlv_count = CW'(cnt); dlv_vec = VW'(vec);
  endtask

  task automatic eoi(input int d, input int vec);
    clear_ev();
    eoi_valid = 1; eoi_dest = DW'(d); eoi_vec = VW'(vec);
  endtask

  task automatic restore(input int d, input bit p);
    clear_ev();
    restore_valid = 1; restore_dest = DW'(d); restore_pend = p;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: state after reset
    tag = "R1";
    idle(1);
    check("R1 count after reset", 32'(pend_count), 0);
    check("R1 map after reset", 32'(pend_map), 0);

    // R3: accepted delivery to destinations 0, 2, 3 with vector 0x41
    tag = "R3";
    deliver(1, 8'b0000_1101, 3, 'h41);
    idle(1);
    check("R3 count loaded", 32'(pend_count), 3);
    check("R3 map loaded", 32'(pend_map), 32'h0d);
    tag = "R2";
    check("R2 coalesced with count 3", 32'(coalesced), 1);

    // R4: delivery refused while coalesced
    tag = "R4";
    deliver(1, 8'b1111_0000, 4, 'h50);
    idle(1);
    check("R4 drop pulse", 32'(req_drop), 1);
    check("R4 map kept", 32'(pend_map), 32'h0d);
    idle(1);
    check("R4 drop single cycle", 32'(req_drop), 0);

    // R6: EOI on a clear bit and with a stale vector
    tag = "R6";
    eoi(1, 'h41);
    eoi(0, 'h42);
    idle(1);
    check("R6 count untouched", 32'(pend_count), 3);

    // R5: matching EOIs retire one by one
    tag = "R5";
    eoi(0, 'h41);
    idle(1);
    check("R5 count after first EOI", 32'(pend_count), 2);
    eoi(2, 'h41);
    eoi(3, 'h41);
    idle(1);
    check("R5 count drained", 32'(pend_count), 0);
    check("R5 coalesced dropped", 32'(coalesced), 0);

    // R3: failed delivery leaves nothing pending
    tag = "R3";
    deliver(0, 8'b0000_0011, 2, 'h22);
    idle(1);
    check("R3 failed delivery count", 32'(pend_count), 0);
    check("R3 failed delivery map", 32'(pend_map), 0);

    // R8: reported count smaller than the bitmap forces an underflow rebuild
    tag = "R8";
    line_vec = 'h77;
    dest_live = 8'b1010_0000;
    deliver(1, 8'b0000_0011, 1, 'h33);
    eoi(0, 'h33);
    eoi(1, 'h33);
    idle(1);
    check("R8 resync pulse", 32'(resync), 1);
    check("R8 rebuilt map", 32'(pend_map), 32'ha0);
    check("R8 rebuilt count", 32'(pend_count), 2);

    // R7: restore set, repeated set, clear
    tag = "R7";
    restore(4, 1);
    idle(1);
    check("R7 count after set", 32'(pend_count), 3);
    restore(4, 1);
    restore(5, 0);
    idle(1);
    check("R7 count after clear", 32'(pend_count), 2);
    check("R7 map after clear", 32'(pend_map), 32'h90);
    restore(4, 0);
    restore(7, 0);
    idle(1);
    check("R7 drained", 32'(pend_count), 0);
    // saturation at the top count
    deliver(1, 8'b0000_0001, 15, 'h10);
    restore(1, 1);
    idle(1);
    check("R7 saturated count", 32'(pend_count), 15);

    // R9: restore wins over EOI and delivery in the same cycle
    tag = "R9";
    clear_ev();
    restore_valid = 1; restore_dest = 3; restore_pend = 1;
    eoi_valid = 1; eoi_dest = 0; eoi_vec = 'h10;
    dlv_valid = 1; dlv_ok = 1; dlv_map = 8'hff; dlv_count = 8; dlv_vec = 'h99;
    idle(1);
    check("R9 EOI ignored", 32'(pend_map), 32'h0b);
    check("R9 delivery refused", 32'(req_drop), 1);

    // R10: random traffic, query port compared every cycle
    tag = "R10";
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom % 8;
      line_vec = VW'('h30 + ($urandom % 2));
      dest_live = ND'($urandom);
      case (r)
        0, 1: deliver($urandom % 4 != 0, ND'($urandom), $urandom % 9, 'h30 + ($urandom % 2));
        2, 3, 4: eoi($urandom % ND, 'h30 + ($urandom % 2));
        5: restore($urandom % ND, 1'($urandom));
        default: idle(1);
      endcase
    end
    idle(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule